// File: doc/BRIEF.md
# Backup Cache Access Controller

This block sits between a processor core and an external backup cache built from ordinary SRAMs. When the core asks for a 32-byte line, the controller places a quadword address on the SRAM pins. It then waits a power-up-selected number of CPU cycles for the tag, the line state bits and the data to come back, and judges the line state. A read of a valid line with a matching tag completes on chip. A write completes on chip only when the line is valid and not shared, and it then writes the line back with the dirty bit set. Every other case goes to an external system agent.

The agent runs on a slower system clock that the controller makes by dividing the CPU clock by a mode value. The controller raises a request code on a system-clock edge and holds it, with the line address, until the agent has acknowledged both 16-byte halves of the line. The SRAM data path works in one of two modes. In 128-bit mode a line moves in two beats. In 64-bit mode it moves in four beats, and only the low 64 bits of the data pins are used. A cache-disable mode bit sends every access straight to the agent.

Top module: `bcache_ctl`

## Requirements
- R1: Each SRAM read beat keeps `sr_oe` high and `sr_addr` stable for N CPU cycles, where N is `cfg_rd_wait` clamped to 3..16. The tag, state and data are sampled only at the end of the N-th cycle.
- R2: Each SRAM write beat lasts T cycles, where T is `cfg_wr_total` (0 counts as 1). Within the beat, `sr_we` is high in cycles `cfg_wr_start` to `cfg_wr_start+cfg_wr_width-1`, counted from 0, and any part of that range at or beyond T is cut off.
- R3: A read whose first beat returns a matching tag with valid set completes locally, whatever the shared bit says. `rsp_local` is 1 and `rsp_data` holds the beats in ascending order.
- R4: A write first does one read beat to fetch the state. It completes locally only when the tag matches, valid is 1 and shared is 0. While `sr_we` is high, `sr_wctl` is 3'b101: bit 2 is valid, bit 1 is shared and bit 0 is dirty.
- R5: Every access that does not complete locally goes to the agent on `sys_req`. The codes are 3'b001 for a read block and 3'b010 for a write block, with 3'b000 meaning no request. No other code ever appears.
- R6: `sys_clk` has a period of D CPU cycles, where D is `cfg_sys_div` clamped to 2..8. It is high for the first floor(D/2) cycles of each period, and the phase starts at the release of reset.
- R7: `sys_req` changes only at a `sys_clk` rising edge. The code and `sys_addr` stay fixed until the second acknowledge. `sys_ack` counts only in the CPU cycle just before a `sys_clk` rise.
- R8: With a request pending, `sys_addr` carries the line address, `sys_qw` the starting quadword and `sys_instr` the instruction/data flag. For a read block, the first acknowledged 16-byte chunk fills `rsp_data[127:0]` and the second fills `rsp_data[255:128]`. For a write block, `sys_wdata` shows the low half of the line until the first acknowledge and the high half after it.
- R9: In 128-bit mode a line moves in 2 beats, and the low two bits of `sr_addr` are 0 and then 2. In 64-bit mode it moves in 4 beats, those bits are 0 to 3, and only data bits [63:0] are used.
- R10: With `cfg_cache_off` set, an access raises no SRAM read or write and goes straight to the agent.
- R11: `req_ready` is high only while the controller is idle. `rsp_valid` is a one-cycle pulse in the cycle after the last data transfer.
- R12: After reset, `req_ready` is 1, `rsp_valid`, `sr_oe`, `sr_we` and `sys_req` are 0, and `sys_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_rd_wait | input | 5 | SRAM read wait in CPU cycles |
| cfg_wr_total | input | 5 | length of an SRAM write beat |
| cfg_wr_start | input | 5 | first strobe cycle within a write beat |
| cfg_wr_width | input | 5 | strobe length in cycles |
| cfg_sys_div | input | 4 | CPU-to-system clock divisor |
| cfg_bus64 | input | 1 | 1 selects 64-bit SRAM data mode |
| cfg_cache_off | input | 1 | send every access to the agent |
| req_valid | input | 1 | access request |
| req_ready | output | 1 | controller idle and able to accept |
| req_write | input | 1 | 1 = line write |
| req_instr | input | 1 | 1 = instruction stream access |
| req_addr | input | ADDR_W-3 | quadword address |
| req_wdata | input | LINE_W | line to write |
| rsp_valid | output | 1 | access finished |
| rsp_local | output | 1 | finished without the agent |
| rsp_data | output | LINE_W | line read |
| sr_addr | output | ADDR_W-3 | SRAM quadword address |
| sr_oe | output | 1 | SRAM read enable |
| sr_we | output | 1 | SRAM write strobe |
| sr_wdata | output | LINE_W/2 | SRAM write data |
| sr_wtag | output | TAG_W | tag written with the line |
| sr_wctl | output | 3 | state bits written {valid, shared, dirty} |
| sr_rdata | input | LINE_W/2 | SRAM read data |
| sr_tag | input | TAG_W | SRAM tag |
| sr_valid | input | 1 | line valid bit |
| sr_shared | input | 1 | line shared bit |
| sys_clk | output | 1 | divided system clock |
| sys_req | output | 3 | request code to the agent |
| sys_addr | output | ADDR_W-5 | line address for the agent |
| sys_qw | output | 2 | starting quadword |
| sys_instr | output | 1 | instruction/data flag |
| sys_wdata | output | LINE_W/2 | write-block data chunk |
| sys_ack | input | 1 | agent acknowledge |
| sys_rdata | input | LINE_W/2 | read-block data chunk |

## Verification
The local path is tried with reads in both bus modes, with wait values below, inside and above the legal range, and with write beats whose strobe fits in the beat or is cut by it. On each read beat the SRAM model gives correct tag, state and data in the N-th cycle only and misleading values in every other cycle, so sampling one cycle early or late turns a hit into a miss, or the other way round. The agent path is driven by a read of an invalid line, a read with a tag mismatch, a write to a shared line, a write to an invalid line and an access with the cache disabled, each at a different divisor. In each case a stray acknowledge arrives on a cycle that is not a system-clock edge, and this separates correct edge sampling from sampling on any cycle.

// File: rtl/bcache_ctl.sv
module bcache_ctl #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           cfg_rd_wait,
  input  logic [4:0]           cfg_wr_total,
  input  logic [4:0]           cfg_wr_start,
  input  logic [4:0]           cfg_wr_width,
  input  logic [3:0]           cfg_sys_div,
  input  logic                 cfg_bus64,
  input  logic                 cfg_cache_off,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_instr,
  input  logic [ADDR_W-4:0]    req_addr,
  input  logic [LINE_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_local,
  output logic [LINE_W-1:0]    rsp_data,
  output logic [ADDR_W-4:0]    sr_addr,
  output logic                 sr_oe,
  output logic                 sr_we,
  output logic [LINE_W/2-1:0]  sr_wdata,
  output logic [TAG_W-1:0]     sr_wtag,
  output logic [2:0]           sr_wctl,
  input  logic [LINE_W/2-1:0]  sr_rdata,
  input  logic [TAG_W-1:0]     sr_tag,
  input  logic                 sr_valid,
  input  logic                 sr_shared,
  output logic                 sys_clk,
  output logic [2:0]           sys_req,
  output logic [ADDR_W-6:0]    sys_addr,
  output logic [1:0]           sys_qw,
  output logic                 sys_instr,
  output logic [LINE_W/2-1:0]  sys_wdata,
  input  logic                 sys_ack,
  input  logic [LINE_W/2-1:0]  sys_rdata
);
  localparam int HALF = LINE_W / 2;
  localparam int QW   = LINE_W / 4;
  localparam logic [2:0] RQ_IDLE = 3'b000;
  localparam logic [2:0] RQ_RD   = 3'b001;
  localparam logic [2:0] RQ_WR   = 3'b010;

  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_WR, S_SREQ, S_SACK} st_t;

  st_t               st;
  logic [4:0]        cnt;
  logic [1:0]        beat;
  logic [ADDR_W-4:0] qa_q;
  logic              wr_q, instr_q, sack_n;
  logic [LINE_W-1:0] line_q;
  logic [2:0]        req_q;
  logic [3:0]        divcnt;

  logic [4:0] rd_n, wr_t;
  logic [3:0] div_n;
  logic [5:0] we_end;
  logic       tick, last_beat, sample, tag_hit, rd_ok, wr_ok, wr_last;
  logic [1:0] qidx;

  assign rd_n   = (cfg_rd_wait < 5'd3) ? 5'd3 : (cfg_rd_wait > 5'd16) ? 5'd16 : cfg_rd_wait;
  assign div_n  = (cfg_sys_div < 4'd2) ? 4'd2 : (cfg_sys_div > 4'd8) ? 4'd8 : cfg_sys_div;
  assign wr_t   = (cfg_wr_total == 5'd0) ? 5'd1 : cfg_wr_total;
  assign we_end = {1'b0, cfg_wr_start} + {1'b0, cfg_wr_width};

  assign tick    = (divcnt == div_n - 4'd1);
  assign sys_clk = (divcnt < (div_n >> 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    divcnt <= '0;
    else if (tick) divcnt <= '0;
    else           divcnt <= divcnt + 4'd1;

  assign last_beat = cfg_bus64 ? (beat == 2'd3) : (beat == 2'd1);
  assign qidx      = cfg_bus64 ? beat : {beat[0], 1'b0};
  assign sample    = (st == S_PROBE) && (cnt == rd_n - 5'd1);
  assign wr_last   = (cnt == wr_t - 5'd1);
  assign tag_hit   = (sr_tag == qa_q[ADDR_W-4 -: TAG_W]);
  assign rd_ok     = tag_hit && sr_valid;
  assign wr_ok     = tag_hit && sr_valid && !sr_shared;

  assign req_ready = (st == S_IDLE);
  assign rsp_data  = line_q;
  assign sr_addr   = {qa_q[ADDR_W-4:2], qidx};
  assign sr_oe     = (st == S_PROBE);
  assign sr_we     = (st == S_WR) && ({1'b0, cnt} >= {1'b0, cfg_wr_start}) && ({1'b0, cnt} < we_end);
  assign sr_wctl   = sr_we ? 3'b101 : 3'b000;
  assign sr_wtag   = qa_q[ADDR_W-4 -: TAG_W];
  assign sr_wdata  = cfg_bus64 ? {{(HALF-QW){1'b0}}, line_q[32'(beat)*QW +: QW]}
                               : line_q[32'(beat[0])*HALF +: HALF];

  assign sys_req   = req_q;
  assign sys_addr  = qa_q[ADDR_W-4:2];
  assign sys_qw    = qa_q[1:0];
  assign sys_instr = instr_q;
  assign sys_wdata = sack_n ? line_q[LINE_W-1:HALF] : line_q[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; beat <= '0; qa_q <= '0; wr_q <= 1'b0; instr_q <= 1'b0;
      sack_n <= 1'b0; line_q <= '0; req_q <= RQ_IDLE; rsp_valid <= 1'b0; rsp_local <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          qa_q <= req_addr; wr_q <= req_write; instr_q <= req_instr; line_q <= req_wdata;
          cnt <= '0; beat <= '0;
          st <= cfg_cache_off ? S_SREQ : S_PROBE;
        end
        S_PROBE: if (sample) begin
          cnt <= '0;
          if (wr_q) begin
            st <= wr_ok ? S_WR : S_SREQ;
          end else if (beat == 2'd0 && !rd_ok) begin
            st <= S_SREQ;
          end else begin
            if (cfg_bus64) line_q[32'(beat)*QW +: QW] <= sr_rdata[QW-1:0];
            else           line_q[32'(beat[0])*HALF +: HALF] <= sr_rdata;
            if (last_beat) begin
              st <= S_IDLE; rsp_valid <= 1'b1; rsp_local <= 1'b1;
            end else beat <= beat + 2'd1;
          end
        end else cnt <= cnt + 5'd1;
        S_WR: if (wr_last) begin
          cnt <= '0;
          if (last_beat) begin
            st <= S_IDLE; rsp_valid <= 1'b1; rsp_local <= 1'b1;
          end else beat <= beat + 2'd1;
        end else cnt <= cnt + 5'd1;
        S_SREQ: if (tick) begin
          req_q <= wr_q ? RQ_WR : RQ_RD; sack_n <= 1'b0; st <= S_SACK;
        end
        S_SACK: if (tick && sys_ack) begin
          if (!sack_n) begin
            if (!wr_q) line_q[HALF-1:0] <= sys_rdata;
            sack_n <= 1'b1;
          end else begin
            if (!wr_q) line_q[LINE_W-1:HALF] <= sys_rdata;
            req_q <= RQ_IDLE; st <= S_IDLE; rsp_valid <= 1'b1; rsp_local <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROBE && cnt != rd_n - 5'd1) |=> (sr_oe && $stable(sr_addr))); // R1
  AST_SHARED_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && wr_q && (sr_shared || !sr_valid)) |=> (st != S_WR)); // R4
  AST_REQ_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req == RQ_IDLE || sys_req == RQ_RD || sys_req == RQ_WR)); // R5
  AST_REQ_ON_SYS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req != $past(sys_req)) |-> $past(tick)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req != RQ_IDLE && !(tick && sys_ack && sack_n)) |=> ($stable(sys_req) && $stable(sys_addr))); // R7
  AST_CACHE_OFF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid && cfg_cache_off) |=> !sr_oe); // R10
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
endmodule

// File: tb/bcache_ctl_tb_top.sv
module bcache_ctl_tb_top;
  localparam int AW = 32, TW = 12, LW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] cfg_rd_wait = 5'd3, cfg_wr_total = 5'd4, cfg_wr_start = 5'd0, cfg_wr_width = 5'd1;
  logic [3:0] cfg_sys_div = 4'd2;
  logic cfg_bus64 = 1'b0, cfg_cache_off = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_instr = 1'b0;
  logic [AW-4:0] req_addr = '0;
  logic [LW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_local;
  logic [LW-1:0] rsp_data;
  logic [AW-4:0] sr_addr;
  logic sr_oe, sr_we;
  logic [LW/2-1:0] sr_wdata, sr_rdata = '0, sys_wdata, sys_rdata = '0;
  logic [TW-1:0] sr_wtag, sr_tag = '0;
  logic [2:0] sr_wctl, sys_req;
  logic sr_valid = 1'b0, sr_shared = 1'b0;
  logic sys_clk, sys_instr, sys_ack = 1'b0;
  logic [AW-6:0] sys_addr;
  logic [1:0] sys_qw;

  bcache_ctl #(.ADDR_W(AW), .TAG_W(TW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd_wait(cfg_rd_wait), .cfg_wr_total(cfg_wr_total),
    .cfg_wr_start(cfg_wr_start), .cfg_wr_width(cfg_wr_width), .cfg_sys_div(cfg_sys_div),
    .cfg_bus64(cfg_bus64), .cfg_cache_off(cfg_cache_off), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_instr(req_instr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_local(rsp_local), .rsp_data(rsp_data),
    .sr_addr(sr_addr), .sr_oe(sr_oe), .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_wtag(sr_wtag),
    .sr_wctl(sr_wctl), .sr_rdata(sr_rdata), .sr_tag(sr_tag), .sr_valid(sr_valid),
    .sr_shared(sr_shared), .sys_clk(sys_clk), .sys_req(sys_req), .sys_addr(sys_addr),
    .sys_qw(sys_qw), .sys_instr(sys_instr), .sys_wdata(sys_wdata), .sys_ack(sys_ack),
    .sys_rdata(sys_rdata));

  int total = 0, bad = 0, k = 0, div_exp = 2;
  bit mon_on = 1'b0, done = 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0; else k <= k + 1;

  task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // R6: system clock phase model, checked every cycle
  always @(negedge clk)
    if (rst_n && mon_on)
      chk(sys_clk == ((k % div_exp) < (div_exp / 2)), "R6 sys_clk", LW'(sys_clk),
          LW'((k % div_exp) < (div_exp / 2)));

  function automatic logic [LW-1:0] mk_line(input int seed);
    logic [LW-1:0] v;
    for (int i = 0; i < LW / 32; i++) v[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i * 7919);
    return v;
  endfunction

  task automatic do_reset(input logic [3:0] div_cfg, input int div_e);
    mon_on = 1'b0;
    rst_n = 1'b0;
    cfg_sys_div = div_cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    div_exp = div_e;
    mon_on = 1'b1;
  endtask

  task automatic issue(input bit wr, input bit ins, input logic [AW-4:0] qa, input logic [LW-1:0] wl);
    chk(req_ready == 1'b1, "R11 req_ready idle", LW'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_instr = ins; req_addr = qa; req_wdata = wl;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 req_ready busy", LW'(req_ready), 0);
  endtask

  // one SRAM read beat: correct values only in the last of n cycles
  task automatic probe(input logic [AW-4:0] qa, input int b, input int n, input logic [LW/2-1:0] gd,
                       input logic [TW-1:0] gt, input bit gv, input bit gs,
                       input logic [TW-1:0] jt, input bit jv, input bit js);
    logic [AW-4:0] ea;
    ea = {qa[AW-4:2], cfg_bus64 ? 2'(b) : {1'(b), 1'b0}};
    for (int c = 0; c < n; c++) begin
      chk(sr_oe == 1'b1 && sr_we == 1'b0, "R1 read beat enables", LW'({sr_oe, sr_we}), 2);
      chk(sr_addr == ea, "R9 beat address", LW'(sr_addr), LW'(ea));
      if (c == n - 1) begin sr_rdata = gd; sr_tag = gt; sr_valid = gv; sr_shared = gs; end
      else begin sr_rdata = ~gd; sr_tag = jt; sr_valid = jv; sr_shared = js; end
      @(negedge clk);
    end
  endtask

  task automatic rd_local(input logic [AW-4:0] qa, input int n, input bit shr, input int seed);
    logic [LW-1:0] ln;
    logic [TW-1:0] tg;
    int nb;
    ln = mk_line(seed);
    tg = qa[AW-4 -: TW];
    nb = cfg_bus64 ? 4 : 2;
    issue(1'b0, 1'b0, qa, '0);
    for (int b = 0; b < nb; b++) begin
      logic [LW/2-1:0] d;
      d = cfg_bus64 ? {64'hDEAD_BEEF_0BAD_F00D, ln[b*64 +: 64]} : ln[b*128 +: 128];
      probe(qa, b, n, d, tg, 1'b1, shr, ~tg, 1'b0, 1'b0);
    end
    chk(rsp_valid == 1'b1 && rsp_local == 1'b1, "R3 local read done", LW'({rsp_valid, rsp_local}), 3);
    chk(rsp_data == ln, "R3 local read data", rsp_data, ln);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp pulse", LW'(rsp_valid), 0);
  endtask

  task automatic wr_local(input logic [AW-4:0] qa, input int n, input int t, input int s, input int w, input int seed);
    logic [LW-1:0] ln;
    logic [TW-1:0] tg;
    int nb;
    ln = mk_line(seed);
    tg = qa[AW-4 -: TW];
    nb = cfg_bus64 ? 4 : 2;
    issue(1'b1, 1'b0, qa, ln);
    probe(qa, 0, n, '0, tg, 1'b1, 1'b0, ~tg, 1'b1, 1'b1);
    for (int b = 0; b < nb; b++) begin
      logic [LW/2-1:0] d;
      d = cfg_bus64 ? {64'h0, ln[b*64 +: 64]} : ln[b*128 +: 128];
      for (int c = 0; c < t; c++) begin
        bit ew;
        ew = (c >= s) && (c < s + w);
        chk(sr_we == ew && sr_oe == 1'b0, "R2 strobe position", LW'({sr_we, sr_oe}), LW'({ew, 1'b0}));
        if (ew) begin
          chk(sr_wctl == 3'b101 && sr_wtag == tg, "R4 dirty written", LW'({sr_wctl, sr_wtag}), LW'({3'b101, tg}));
          chk(sr_wdata == d, "R9 write chunk", LW'(sr_wdata), LW'(d));
        end
        @(negedge clk);
      end
    end
    chk(rsp_valid == 1'b1 && rsp_local == 1'b1, "R4 local write done", LW'({rsp_valid, rsp_local}), 3);
    @(negedge clk);
  endtask

  task automatic ext_flow(input logic [2:0] code, input logic [AW-4:0] qa, input bit ins,
                          input logic [LW-1:0] wl, input int seed, input bit no_sram);
    logic [LW-1:0] rl;
    int guard;
    rl = mk_line(seed);
    guard = 0;
    while (sys_req == 3'b000 && guard < 40) begin
      chk(1'b1, "R7 wait", 0, 0);
      if (no_sram) chk(sr_oe == 1'b0 && sr_we == 1'b0, "R10 no SRAM access", LW'({sr_oe, sr_we}), 0);
      @(negedge clk);
      guard++;
    end
    chk((k % div_exp) == 0, "R7 request on sys_clk rise", LW'(k % div_exp), 0);
    chk(sys_req == code, "R5 request code", LW'(sys_req), LW'(code));
    chk(sys_addr == qa[AW-4:2] && sys_qw == qa[1:0] && sys_instr == ins, "R8 request fields",
        LW'({sys_addr, sys_qw, sys_instr}), LW'({qa[AW-4:2], qa[1:0], ins}));
    if (code == 3'b010) chk(sys_wdata == wl[127:0], "R8 write low half", LW'(sys_wdata), LW'(wl[127:0]));
    sys_ack = 1'b1; sys_rdata = ~rl[127:0];
    for (int ch = 0; ch < 2; ch++) begin
      bit got;
      got = 1'b0;
      while (!got) begin
        @(negedge clk);
        if ((k % div_exp) == div_exp - 1) begin
          sys_ack = 1'b1; sys_rdata = rl[ch*128 +: 128]; got = 1'b1;
        end else begin
          sys_ack = 1'b0;
          chk(sys_req == code, "R7 request held", LW'(sys_req), LW'(code));
        end
      end
      @(negedge clk);
      sys_ack = 1'b0;
      if (ch == 0) begin
        chk(sys_req == code && rsp_valid == 1'b0, "R7 held after first ack", LW'({sys_req, rsp_valid}), LW'({code, 1'b0}));
        if (code == 3'b010) chk(sys_wdata == wl[255:128], "R8 write high half", LW'(sys_wdata), LW'(wl[255:128]));
      end
    end
    chk(sys_req == 3'b000, "R5 idle code after done", LW'(sys_req), 0);
    chk(rsp_valid == 1'b1 && rsp_local == 1'b0, "R5 external done", LW'({rsp_valid, rsp_local}), 2);
    if (code == 3'b001) chk(rsp_data == rl, "R8 read block data", rsp_data, rl);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp pulse", LW'(rsp_valid), 0);
  endtask

  initial begin
    logic [AW-4:0] qa;
    logic [LW-1:0] wl;
    do_reset(4'd2, 2);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && sr_oe == 1'b0 && sr_we == 1'b0 && sys_req == 3'b000 && sys_clk == 1'b1,
        "R12 reset state", LW'({req_ready, rsp_valid, sr_oe, sr_we, sys_req, sys_clk}), LW'(9'b1_0_0_0_000_1));

    // R1 clamp low, R3 shared line read locally, R9 128-bit mode
    cfg_rd_wait = 5'd1; cfg_bus64 = 1'b0;
    rd_local(29'h0ABC_1234, 3, 1'b1, 11);
    // R1 clamp high, R9 64-bit mode
    cfg_rd_wait = 5'd20; cfg_bus64 = 1'b1;
    rd_local(29'h1234_5679, 16, 1'b0, 12);
    // R1 mid value
    cfg_rd_wait = 5'd7; cfg_bus64 = 1'b0;
    rd_local(29'h0000_0042, 7, 1'b0, 13);

    // R2/R4 write hit, strobe inside beat (128-bit)
    cfg_rd_wait = 5'd4; cfg_wr_total = 5'd6; cfg_wr_start = 5'd1; cfg_wr_width = 5'd3;
    wr_local(29'h0555_0001, 4, 6, 1, 3, 21);
    // R2 strobe cut off by beat end, 64-bit mode
    cfg_bus64 = 1'b1; cfg_wr_total = 5'd4; cfg_wr_start = 5'd2; cfg_wr_width = 5'd5;
    wr_local(29'h0777_0002, 4, 4, 2, 5, 22);
    cfg_bus64 = 1'b0;

    // R4/R5 write to shared line goes external, divisor 3
    do_reset(4'd3, 3);
    cfg_rd_wait = 5'd3;
    qa = 29'h0321_4567; wl = mk_line(31);
    issue(1'b1, 1'b0, qa, wl);
    probe(qa, 0, 3, '0, qa[AW-4 -: TW], 1'b1, 1'b1, qa[AW-4 -: TW], 1'b1, 1'b0);
    ext_flow(3'b010, qa, 1'b0, wl, 0, 1'b0);

    // R5 read of invalid line, divisor 5, instruction stream
    do_reset(4'd5, 5);
    qa = 29'h0246_8ACE;
    issue(1'b0, 1'b1, qa, '0);
    probe(qa, 0, 3, '0, qa[AW-4 -: TW], 1'b0, 1'b0, qa[AW-4 -: TW], 1'b1, 1'b0);
    ext_flow(3'b001, qa, 1'b1, '0, 41, 1'b0);

    // R3/R5 tag mismatch with valid set, divisor 8
    do_reset(4'd8, 8);
    qa = 29'h1357_9BDF;
    issue(1'b0, 1'b0, qa, '0);
    probe(qa, 0, 3, '0, ~qa[AW-4 -: TW], 1'b1, 1'b0, qa[AW-4 -: TW], 1'b1, 1'b0);
    ext_flow(3'b001, qa, 1'b0, '0, 42, 1'b0);

    // R4 write to invalid line, divisor 4
    do_reset(4'd4, 4);
    qa = 29'h0F0F_0F0E; wl = mk_line(51);
    issue(1'b1, 1'b1, qa, wl);
    probe(qa, 0, 3, '0, qa[AW-4 -: TW], 1'b0, 1'b0, qa[AW-4 -: TW], 1'b1, 1'b0);
    ext_flow(3'b010, qa, 1'b1, wl, 0, 1'b0);

    // R10 cache disabled, R6 divisor clamp 12 -> 8
    do_reset(4'd12, 8);
    cfg_cache_off = 1'b1;
    qa = 29'h0ACE_0003;
    issue(1'b0, 1'b0, qa, '0);
    ext_flow(3'b001, qa, 1'b0, '0, 61, 1'b1);
    // R6 divisor clamp 1 -> 2, disabled write
    do_reset(4'd1, 2);
    qa = 29'h0BEE_0001; wl = mk_line(71);
    issue(1'b1, 1'b0, qa, wl);
    ext_flow(3'b010, qa, 1'b0, wl, 0, 1'b1);
    cfg_cache_off = 1'b0;

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule